// File: doc/BRIEF.md
# Interrupt-on-Change Port Monitor

This block watches one parallel input port and raises an interrupt when an enabled pin changes state. Each pin can be set to one of two tests. In change mode the pin is compared with its own level one clock earlier. In default mode it is compared with a programmed reference bit. When the interrupt fires, the block stores the set of pins that caused it in a flag register and stores the port levels in a capture register. Both registers then hold their values until software clears the interrupt by reading the port or the capture register. A pin held in default mode keeps the interrupt pending for as long as its level differs from its reference, even across reads.

The interrupt pin can be driven active-high, active-low or as an open-drain pull-down. A mirror setting ORs in the pending state of a partner port monitor, so that either port can signal events from both. The pin levels arrive already synchronized. Register writes use a small select code, and reads are a combinational mux. Separate single-cycle strobes mark the reads that clear the interrupt.

Top module: `ioc_port_mon`

## Requirements
- R1: After reset, the enable, mode, reference, config, flag and capture registers are all zero and nothing is pending. With config 0 the output is active-low push-pull idle, so `int_oe`=1 and `int_drv`=1.
- R2: A write with `wr_en` stores `wr_data` at the next edge. The select codes are: 0 enable, 1 mode (1 = default compare), 2 reference, 3 config (3 bits). `rd_data` returns these for the same codes. It returns the flag for code 4, the capture for code 5 and the live pins for code 6. Code 7 reads as zero. The config value is zero-extended.
- R3: An enabled pin in change mode whose level differs from its level at the previous clock edge sets `int_pend` at that edge, provided nothing is pending.
- R4: An enabled pin in default mode whose level is the opposite of its reference bit sets `int_pend` at that edge, provided nothing is pending.
- R5: A pin whose enable bit is 0 never causes an interrupt and never appears in the flag.
- R6: When the interrupt fires, the flag takes the set of triggering pins and the capture takes the pin levels, both at that edge. While pending and not cleared, neither changes.
- R7: A write with select code 4 has no effect on the flag.
- R8: `rd_port_evt` or `rd_cap_evt` while pending clears `int_pend` and the flag at the next edge, provided no default-mode mismatch is present. The previous-level reference is reloaded from the pins at the clearing edge, so a change made while pending does not re-trigger.
- R9: A clear while an enabled default-mode pin mismatches keeps `int_pend` at 1. The flag is reloaded with the current default-mode mismatches and the capture with the current pins.
- R10: Config bit 1 = 0 selects push-pull with `int_oe`=1: `int_drv` equals the active state when config bit 0 = 1, and its inverse when bit 0 = 0. Config bit 1 = 1 selects open-drain with `int_drv`=0 and `int_oe` equal to the active state.
- R11: The active state is `int_pend`, ORed with `partner_pend` when config bit 2 (mirror) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins | input | W | Synchronized pin levels |
| partner_pend | input | 1 | Pending state of the partner port |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write select code |
| wr_data | input | W | Write data |
| rd_sel | input | 3 | Read select code |
| rd_data | output | W | Read data |
| rd_port_evt | input | 1 | Port-register read event |
| rd_cap_evt | input | 1 | Capture-register read event |
| int_pend | output | 1 | This port's pending interrupt |
| int_drv | output | 1 | Interrupt pin drive value |
| int_oe | output | 1 | Interrupt pin output enable |

## Verification
On every cycle, the assertions check four things. Flag and capture stay frozen while an interrupt is pending and uncleared. A clear with no default mismatch drops the pending state. A new interrupt always carries at least one flag bit. Open-drain never drives high. Only the bench scenarios can show the rest. That covers the choice between the two compare tests, the loss of changes that occur during a pending interrupt, the persistence of default-mode mismatches across reads, the ignored flag write, and the mirror and polarity combinations. The bench checks these against a behavioural model on every clock.

// File: rtl/ioc_port_mon.sv
module ioc_port_mon #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic         partner_pend,
  input  logic         wr_en,
  input  logic [2:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [2:0]   rd_sel,
  output logic [W-1:0] rd_data,
  input  logic         rd_port_evt,
  input  logic         rd_cap_evt,
  output logic         int_pend,
  output logic         int_drv,
  output logic         int_oe
);
  localparam int CW = 3;

  logic [W-1:0]  en_q, mode_q, ref_q, prev_q, flag_q, cap_q;
  logic [CW-1:0] cfg_q;
  logic          pend_q;

  wire [W-1:0] chg_hit = en_q & ~mode_q & (pins ^ prev_q);
  wire [W-1:0] dft_hit = en_q &  mode_q & (pins ^ ref_q);
  wire [W-1:0] hit     = chg_hit | dft_hit;
  wire         clr     = pend_q & (rd_port_evt | rd_cap_evt);
  wire         active  = pend_q | (cfg_q[2] & partner_pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; mode_q <= '0; ref_q <= '0; cfg_q <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        3'd0: en_q   <= wr_data;
        3'd1: mode_q <= wr_data;
        3'd2: ref_q  <= wr_data;
        3'd3: cfg_q  <= wr_data[CW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0; flag_q <= '0; cap_q <= '0; prev_q <= '0;
    end else begin
      if (!pend_q || clr) prev_q <= pins;
      if (clr) begin
        if (|dft_hit) begin
          flag_q <= dft_hit;
          cap_q  <= pins;
        end else begin
          pend_q <= 1'b0;
          flag_q <= '0;
        end
      end else if (!pend_q && |hit) begin
        pend_q <= 1'b1;
        flag_q <= hit;
        cap_q  <= pins;
      end
    end
  end

  always_comb begin
    case (rd_sel)
      3'd0:    rd_data = en_q;
      3'd1:    rd_data = mode_q;
      3'd2:    rd_data = ref_q;
      3'd3:    rd_data = {{(W-CW){1'b0}}, cfg_q};
      3'd4:    rd_data = flag_q;
      3'd5:    rd_data = cap_q;
      3'd6:    rd_data = pins;
      default: rd_data = '0;
    endcase
  end

  assign int_pend = pend_q;
  assign int_oe   = cfg_q[1] ? active : 1'b1;
  assign int_drv  = cfg_q[1] ? 1'b0 : (cfg_q[0] ? active : ~active);

  // R6
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pend && !rd_port_evt && !rd_cap_evt) |=> ($stable(flag_q) && $stable(cap_q)));
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pend && (rd_port_evt || rd_cap_evt) && !(|(en_q & mode_q & (pins ^ ref_q)))) |=> !int_pend);
  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_pend) |-> (flag_q != '0));
  // R10
  open_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[1] |-> !int_drv);
endmodule

// File: tb/ioc_port_mon_test.sv
module ioc_port_mon_test;
  localparam int W = 8;
  logic clk = 0, rst_n = 0;
  logic [W-1:0] pins = 0, wr_data = 0, rd_data;
  logic partner_pend = 0, wr_en = 0, rd_port_evt = 0, rd_cap_evt = 0;
  logic [2:0] wr_sel = 0, rd_sel = 0;
  logic int_pend, int_drv, int_oe;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  ioc_port_mon #(.W(W)) uut (.clk(clk), .rst_n(rst_n), .pins(pins), .partner_pend(partner_pend),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .rd_port_evt(rd_port_evt), .rd_cap_evt(rd_cap_evt), .int_pend(int_pend),
    .int_drv(int_drv), .int_oe(int_oe));

  always #2 clk = ~clk;

  logic [W-1:0] m_en = 0, m_mode = 0, m_ref = 0, m_prev = 0, m_flag = 0, m_cap = 0;
  logic [2:0] m_cfg = 0;
  bit m_pend = 0;

  always @(posedge clk) begin
    logic [W-1:0] h, dh;
    bit c;
    cyc++;
    if (!rst_n) begin
      m_en = 0; m_mode = 0; m_ref = 0; m_cfg = 0; m_prev = 0; m_flag = 0; m_cap = 0; m_pend = 0;
    end else begin
      h = 0; dh = 0;
      for (int i = 0; i < W; i++) begin
        if (m_en[i] && m_mode[i] && pins[i] != m_ref[i]) dh[i] = 1;
        if (m_en[i] && !m_mode[i] && pins[i] != m_prev[i]) h[i] = 1;
      end
      h = h | dh;
      c = m_pend && (rd_port_evt || rd_cap_evt);
      if (!m_pend || c) m_prev = pins;
      if (c) begin
        if (dh != 0) begin m_flag = dh; m_cap = pins; end
        else begin m_pend = 0; m_flag = 0; end
      end else if (!m_pend && h != 0) begin
        m_pend = 1; m_flag = h; m_cap = pins;
      end
      if (wr_en) begin
        if (wr_sel == 0) m_en = wr_data;
        else if (wr_sel == 1) m_mode = wr_data;
        else if (wr_sel == 2) m_ref = wr_data;
        else if (wr_sel == 3) m_cfg = wr_data[2:0];
      end
    end
  end

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    bit a;
    logic [W-1:0] e;
    a = m_pend | (m_cfg[2] & partner_pend);
    if (!rst_n) chk("R1 pend", {7'b0, int_pend}, 0);
    else chk("R3/R4/R8/R9 pend", {7'b0, int_pend}, {7'b0, m_pend});
    chk("R10/R11 oe", {7'b0, int_oe}, {7'b0, m_cfg[1] ? a : 1'b1});
    chk("R10/R11 drv", {7'b0, int_drv}, {7'b0, m_cfg[1] ? 1'b0 : (m_cfg[0] ? a : ~a)});
    case (rd_sel)
      0: e = m_en; 1: e = m_mode; 2: e = m_ref; 3: e = {5'b0, m_cfg};
      4: e = m_flag; 5: e = m_cap; 6: e = pins; default: e = 0;
    endcase
    chk(rd_sel == 4 ? "R5/R6/R7 flag" : rd_sel == 5 ? "R6 capture" : "R2 read", rd_data, e);
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
    wr_en = 0; rd_port_evt = 0; rd_cap_evt = 0;
  endtask
  task automatic wr(logic [2:0] s, logic [W-1:0] d);
    wr_en = 1; wr_sel = s; wr_data = d; step();
  endtask

  initial begin
    rd_sel = 3;
    step(3);
    rst_n = 1;
    step();
    // R2 register map
    wr(0, 8'h0F); wr(1, 8'h0C); wr(2, 8'h08); wr(3, 3'b000);
    rd_sel = 4;
    // R3 change mode on bit0
    pins = 8'h08; step(2);
    pins = 8'h09; step(2);
    // R6 frozen while pending
    pins = 8'h0B; step(2);
    // R7 flag write ignored
    wr(4, 8'hFF); step();
    // R8 clear via port read
    rd_port_evt = 1; step(2);
    // R4/R9 default mismatch on bit2
    pins = 8'h0F; step(2);
    rd_cap_evt = 1; step(2);
    pins = 8'h0B; rd_cap_evt = 1; step(2);
    // R5 disabled pins
    pins = 8'hFB; step(3);
    // R10/R11 output modes
    partner_pend = 1;
    for (int c = 0; c < 8; c++) begin wr(3, c[2:0]); step(); end
    partner_pend = 0;
    for (int k = 0; k < 4000; k++) begin
      rd_sel = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) pins = pins ^ (8'h1 << $urandom_range(0, 7));
      partner_pend = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 9) == 0) begin
        wr_en = 1; wr_sel = 3'($urandom_range(0, 7)); wr_data = 8'($urandom);
      end
      rd_port_evt = ($urandom_range(0, 7) == 0);
      rd_cap_evt  = ($urandom_range(0, 7) == 0);
      @(posedge clk); #1;
      wr_en = 0; rd_port_evt = 0; rd_cap_evt = 0;
    end
    step(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    done = 1;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule